// File: doc/BRIEF.md
# Serial Receiver with Sticky Line Status

This block recovers asynchronous serial characters from a single input line that idles high. A 16x oversampling enable paces it. Each character has a start bit, five to eight data bits sent least significant bit first, an optional parity bit and one stop bit. The receiver confirms each start bit at its half-bit point and samples every later bit at its centre. It places the finished character in a one-entry holding register.

Alongside the character it keeps five status flags. Data-ready marks an unread character. Overrun, parity error, framing error and break are sticky: they stay set until software reads the status register. The word-length and parity controls are the same ones that set up the transmitter, and they include a stick-parity mode. A host reads the data register with one strobe and the status register with another.

Top module: `uart_rx_line`

## Requirements
- R1: After reset, rx_data is zero and data_ready, overrun, parity_err, framing_err and break_det are all low.
- R2: wlen selects the character length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. The first data bit on the line lands in rx_data[0], and the bits above the chosen length read zero.
- R3: data_ready goes high when a character completes into an empty holding register. A pulse on rd_data clears it.
- R4: A character that completes while data_ready is high and rd_data is not pulsed sets overrun. The unread character stays in rx_data and the new one is dropped.
- R5: With par_en high, one parity bit follows the data. With par_even high the expected bit makes the count of ones in data plus parity even; with par_even low it makes that count odd. A mismatch sets parity_err. With par_en low no parity bit is expected and parity_err is never set.
- R6: With par_en and par_stick both high, the expected parity bit is the inverse of par_even, whatever the data.
- R7: A stop bit sampled low sets framing_err.
- R8: A frame whose data bits, parity bit (when enabled) and stop bit are all low sets break_det and framing_err, and loads zero as the character.
- R9: A pulse on rd_stat clears overrun, parity_err, framing_err and break_det. It does not clear data_ready.
- R10: A low pulse shorter than half a bit period is ignored as a glitch and produces no character.
- R11: After a frame, a new start bit is accepted only once the line has been seen high, so a line held low produces a single break character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial input line, idle high |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| wlen | input | 2 | Word-length select (0..3 gives 5..8 bits) |
| par_en | input | 1 | Parity bit present and checked |
| par_even | input | 1 | Even parity when high, odd parity when low |
| par_stick | input | 1 | Fixed parity value of the inverse of par_even |
| rd_data | input | 1 | Data register read strobe |
| rd_stat | input | 1 | Status register read strobe |
| rx_data | output | 8 | Received character |
| data_ready | output | 1 | Unread character present |
| overrun | output | 1 | Sticky: character lost to overrun |
| parity_err | output | 1 | Sticky: parity mismatch seen |
| framing_err | output | 1 | Sticky: low stop bit seen |
| break_det | output | 1 | Sticky: break frame seen |

## Verification
The assertions assume that wlen, par_en, par_even and par_stick stay steady while a frame is on the line. They also assume that rd_data and rd_stat are single-cycle pulses. The bench changes the line controls and pulses the read strobes only after a frame's stop bit has been sampled and the line has returned high. Every bit it drives lasts exactly sixteen oversampling ticks, so each centre sample lands well clear of a bit edge.

// File: rtl/uart_rx_line.sv
module uart_rx_line #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       os_tick,
  input  logic [1:0] wlen,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  input  logic       rd_data,
  input  logic       rd_stat,
  output logic [7:0] rx_data,
  output logic       data_ready,
  output logic       overrun,
  output logic       parity_err,
  output logic       framing_err,
  output logic       break_det
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           st;
  logic [1:0]    sync;
  logic          rxd_s;
  logic          armed;
  logic [CW-1:0] cnt;
  logic [2:0]    idx;
  logic [7:0]    shreg;
  logic          pbit;
  logic          frame_done;
  logic          exp_par;
  logic          brk;
  logic [2:0]    last_idx;

  assign rxd_s      = sync[1];
  assign last_idx   = 3'(wlen) + 3'd4;
  assign frame_done = (st == S_STOP) && os_tick && (cnt == LAST);
  assign exp_par    = par_stick ? ~par_even : (par_even ? ^shreg : ~^shreg);
  assign brk        = (shreg == 8'd0) && (!par_en || !pbit) && !rxd_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      armed <= 1'b0;
      cnt   <= '0;
      idx   <= '0;
      shreg <= '0;
      pbit  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (rxd_s) armed <= 1'b1;
          if (os_tick && armed && !rxd_s) begin
            st    <= S_START;
            cnt   <= '0;
            armed <= 1'b0;
          end
        end
        S_START: if (os_tick) begin
          if (cnt == MID) begin
            if (!rxd_s) begin
              st    <= S_DATA;
              cnt   <= '0;
              idx   <= '0;
              shreg <= '0;
              pbit  <= 1'b0;
            end else begin
              st <= S_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DATA: if (os_tick) begin
          if (cnt == LAST) begin
            shreg[idx] <= rxd_s;
            cnt        <= '0;
            if (idx == last_idx) st <= par_en ? S_PAR : S_STOP;
            else                 idx <= idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PAR: if (os_tick) begin
          if (cnt == LAST) begin
            pbit <= rxd_s;
            cnt  <= '0;
            st   <= S_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STOP: if (os_tick) begin
          if (cnt == LAST) begin
            st  <= S_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data     <= '0;
      data_ready  <= 1'b0;
      overrun     <= 1'b0;
      parity_err  <= 1'b0;
      framing_err <= 1'b0;
      break_det   <= 1'b0;
    end else begin
      if (rd_data) data_ready <= 1'b0;
      if (rd_stat) begin
        overrun     <= 1'b0;
        parity_err  <= 1'b0;
        framing_err <= 1'b0;
        break_det   <= 1'b0;
      end
      if (frame_done) begin
        if (data_ready && !rd_data) begin
          overrun <= 1'b1;
        end else begin
          rx_data    <= brk ? 8'd0 : shreg;
          data_ready <= 1'b1;
        end
        if (!rxd_s) framing_err <= 1'b1;
        if (par_en && (pbit != exp_par)) parity_err <= 1'b1;
        if (brk) break_det <= 1'b1;
      end
    end
  end
endmodule

module uart_rx_line_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_data,
  input logic       rd_stat,
  input logic       frame_done,
  input logic [7:0] rx_data,
  input logic       data_ready,
  input logic       overrun,
  input logic       parity_err,
  input logic       framing_err,
  input logic       break_det
);
  // R9
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat && !frame_done |=> !overrun && !parity_err && !framing_err && !break_det);
  // R3
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data && !frame_done |=> !data_ready);
  // R3
  ready_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ready) |-> $past(frame_done));
  // R4
  overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $stable(rx_data) && $past(data_ready));
  // R5
  parity_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(parity_err) |-> $past(frame_done));
  // R7
  framing_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(framing_err) |-> $past(frame_done));
  // R8
  break_framing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(break_det) |-> framing_err && rx_data == 8'd0);
endmodule

bind uart_rx_line uart_rx_line_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .rd_stat(rd_stat),
  .frame_done(frame_done), .rx_data(rx_data), .data_ready(data_ready),
  .overrun(overrun), .parity_err(parity_err), .framing_err(framing_err),
  .break_det(break_det)
);

// File: tb/sim_uart_rx_line.sv
module sim_uart_rx_line;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLKS   = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       os_tick = 1'b0;
  logic [1:0] wlen = 2'd3;
  logic       par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0;
  logic       rd_data = 1'b0, rd_stat = 1'b0;
  logic [7:0] rx_data;
  logic       data_ready, overrun, parity_err, framing_err, break_det;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [7:0] m_data = 0;
  logic m_dr = 0, m_ov = 0, m_pe = 0, m_fe = 0, m_bi = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) os_tick <= ~os_tick;

  uart_rx_line u0 (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .os_tick(os_tick), .wlen(wlen),
    .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
    .rd_data(rd_data), .rd_stat(rd_stat), .rx_data(rx_data),
    .data_ready(data_ready), .overrun(overrun), .parity_err(parity_err),
    .framing_err(framing_err), .break_det(break_det)
  );

  function automatic logic [7:0] mask_of(input logic [1:0] wl);
    return 8'hFF >> (3 - wl);
  endfunction

  function automatic logic want_par(input logic [7:0] d, input logic ev, input logic st);
    if (st) return ~ev;
    return ev ? ^d : ~^d;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R2 R3 rx_data"}, rx_data, m_data);
    chk({tag, " R3 data_ready"}, {7'd0, data_ready}, {7'd0, m_dr});
    chk({tag, " R4 overrun"}, {7'd0, overrun}, {7'd0, m_ov});
    chk({tag, " R5 R6 parity_err"}, {7'd0, parity_err}, {7'd0, m_pe});
    chk({tag, " R7 framing_err"}, {7'd0, framing_err}, {7'd0, m_fe});
    chk({tag, " R8 break_det"}, {7'd0, break_det}, {7'd0, m_bi});
  endtask

  task automatic bit_out(input logic v);
    rxd = v;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] d, input logic pv, input logic sb, input int hold_low);
    logic [7:0] dm;
    logic brk;
    dm = d & mask_of(wlen);
    bit_out(1'b0);
    for (int i = 0; i <= int'(wlen) + 4; i++) bit_out(dm[i]);
    if (par_en) bit_out(pv);
    bit_out(sb);
    repeat (hold_low) bit_out(1'b0);
    rxd = 1'b1;
    repeat (40) @(negedge clk);
    brk = (dm == 0) && (!par_en || !pv) && !sb;
    if (m_dr) m_ov = 1;
    else begin m_data = brk ? 8'd0 : dm; m_dr = 1; end
    if (!sb) m_fe = 1;
    if (par_en && pv != want_par(dm, par_even, par_stick)) m_pe = 1;
    if (brk) m_bi = 1;
  endtask

  task automatic read_data();
    @(negedge clk) rd_data = 1'b1;
    @(negedge clk) rd_data = 1'b0;
    m_dr = 0;
  endtask

  task automatic read_stat();
    @(negedge clk) rd_stat = 1'b1;
    @(negedge clk) rd_stat = 1'b0;
    m_ov = 0; m_pe = 0; m_fe = 0; m_bi = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1'b1;
    repeat (8) @(negedge clk);

    // R2: every word length
    for (int w = 0; w < 4; w++) begin
      wlen = 2'(w);
      frame(8'hA7, 1'b0, 1'b1, 0);
      check_all("R2 wlen");
      read_data();
    end

    // R5: even and odd parity, correct then wrong
    wlen = 2'd3; par_en = 1'b1; par_even = 1'b1;
    frame(8'h35, want_par(8'h35, 1'b1, 1'b0), 1'b1, 0);
    check_all("R5 even ok");
    read_data();
    par_even = 1'b0;
    frame(8'h35, ~want_par(8'h35, 1'b0, 1'b0), 1'b1, 0);
    check_all("R5 odd bad");
    read_data(); read_stat();
    check_all("R9 cleared");

    // R6: stick parity
    par_stick = 1'b1; par_even = 1'b1;
    frame(8'hFF, 1'b0, 1'b1, 0);
    check_all("R6 stick ok");
    frame(8'h01, 1'b1, 1'b1, 0);
    check_all("R6 stick bad with R4 overrun");
    read_data(); read_stat();
    par_stick = 1'b0; par_en = 1'b0;

    // R7: low stop bit
    frame(8'h5A, 1'b0, 1'b0, 0);
    check_all("R7 framing");
    read_data(); read_stat();

    // R8 and R11: long break, one character only
    frame(8'h00, 1'b0, 1'b0, 12);
    check_all("R8 R11 break");
    read_data(); read_stat();
    check_all("R9 after break");

    // R10: glitch on the line
    rxd = 1'b0; repeat (8) @(negedge clk);
    rxd = 1'b1; repeat (600) @(negedge clk);
    check_all("R10 glitch");

    // R4: overrun keeps the older character
    frame(8'h11, 1'b0, 1'b1, 0);
    frame(8'h22, 1'b0, 1'b1, 0);
    check_all("R4 overrun");
    read_stat();
    check_all("R9 keeps data_ready");
    read_data();

    for (int k = 0; k < 40; k++) begin
      logic [7:0] d;
      logic pv, sb;
      wlen      = 2'($urandom_range(3));
      par_en    = 1'($urandom_range(1));
      par_even  = 1'($urandom_range(1));
      par_stick = 1'($urandom_range(1));
      d  = 8'($urandom);
      pv = want_par(d & mask_of(wlen), par_even, par_stick);
      if ($urandom_range(9) == 0) pv = ~pv;
      sb = ($urandom_range(9) != 0);
      frame(d, pv, sb, 0);
      check_all("random frame");
      if ($urandom_range(3) != 0) read_data();
      if ($urandom_range(1) != 0) read_stat();
      check_all("random after reads R3 R9");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule